// File: doc/BRIEF.md
# Polled Input Port with Four-Phase Device Handshake

This block sits between a processor I/O bus and an input device whose timing is unrelated to the processor clock. The device offers one item at a time. It drives the item on its data lines and raises a valid line. The port takes the item into a single holding register, sets a ready flag and answers with an acknowledge. That acknowledge stays up until the device lowers valid, which gives a four-phase exchange.

The processor finds out that an item is waiting only by polling. It reads a status register and looks at the ready flag, and it raises no interrupt. Once the flag is seen set, software reads the data register. That read clears the flag, and the port can then accept the next item. While an item is still unread, the port withholds its acknowledge. The device therefore waits, and no data is lost. A control register holds an accept-enable bit and a write-one action that discards a waiting item. Every access uses a decoded address together with separate read and write strobes.

Top module: `pio_poll_port`

## Requirements
- R1: After a synchronous active-low reset, the acknowledge is low, the ready flag is 0, accept-enable is 0 and the data register holds 0.
- R2: The device valid line passes through a two-flop synchronizer. With accept enabled and the flag clear, acknowledge and flag rise after the third rising edge that samples valid high.
- R3: On acceptance, three things take effect at the same edge: the data register captures the device data, the flag becomes 1 and acknowledge rises.
- R4: Acknowledge stays high while the synchronized valid is high. It falls after the third rising edge that samples valid low.
- R5: No item is accepted while the flag is 1 or while accept-enable is 0. Acknowledge stays low and the data register is unchanged. A waiting device is accepted one edge after the flag clears.
- R6: A read strobe at the data address (BASE+1) returns the data register and clears the flag at that clock edge.
- R7: A read at the status address (BASE+0) returns the flag in bit 0 and zeros in all other bits, with no side effect.
- R8: At the control address (BASE+2), a write sets accept-enable from bit 0. Writing 1 in bit 1 discards a waiting item by clearing the flag. A read returns accept-enable in bit 0 and zeros elsewhere.
- R9: With the read strobe low, or at any unmapped address, read data is zero. Writes to addresses other than BASE+2 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data, zero when not reading a mapped register |
| dev_data | input | DATA_W | Device data, held stable while valid is high |
| dev_valid | input | 1 | Device data-valid, asynchronous |
| dev_ack | output | 1 | Data-accepted answer to the device |

## Verification
The bench measures the latency from a valid edge to the acknowledge edge in both directions. A synchronizer with one stage too few or too many shows up as a wrong cycle count. It offers a second item while the first is still unread. A port that overwrites the holding register, or that acknowledges early, would return the second item on the read or raise acknowledge while the flag is set. It also covers discard through the control register, reads at unmapped addresses and idle bus cycles, where stray read data or a wrong bit position in a control or status field would appear on the data lines. A reference model compares acknowledge and read data on every clock.

// File: rtl/pio_pkg.sv
// Shared definitions for the polled input port: register offsets,
// control-bit positions and the small enums used by the submodules.
package pio_pkg;

    // Register offsets from the port base address.
    localparam int OFS_STAT = 0;
    localparam int OFS_DATA = 1;
    localparam int OFS_CTRL = 2;

    // Control-register bit positions.
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DROP_BIT = 1;

    // Device-side handshake state.
    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hs_state_e;

    // Decoded register selection.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pio_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes the input is a slow level (a handshake line), not a pulse.
module pio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pio_dev_hs.sv
// Device-side handshake and holding register.
// Accepts one item when the synchronized valid is high, the holding
// register is empty and accept is enabled. It then holds acknowledge
// until valid falls. Assumes the device keeps dev_data stable while valid
// is high, so the data lines need no synchronizer.
module pio_dev_hs
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_s,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              accept_en,
    input  logic              take,
    output logic              dev_ack,
    output logic              item_flag,
    output logic [DATA_W-1:0] item_data
);

    hs_state_e         state_q;
    logic              load;
    logic              flag_q;
    logic [DATA_W-1:0] data_q;

    // Accept only from idle, with an empty register and enable set.
    assign load = (state_q == HS_IDLE) && valid_s && !flag_q && accept_en;

    // Handshake state: hold acknowledge until the device drops valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            case (state_q)
                HS_IDLE: if (load)     state_q <= HS_HOLD;
                HS_HOLD: if (!valid_s) state_q <= HS_IDLE;
                default:               state_q <= HS_IDLE;
            endcase
        end
    end

    // Ready flag: set on acceptance, cleared by a processor take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (load) begin
            flag_q <= 1'b1;
        end else if (take) begin
            flag_q <= 1'b0;
        end
    end

    // Holding register: capture device data on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= dev_data;
        end
    end

    assign dev_ack   = (state_q == HS_HOLD);
    assign item_flag = flag_q;
    assign item_data = data_q;

endmodule

// File: rtl/pio_bus_if.sv
// Processor-side decode, control register and read-data multiplexer.
// Assumes single-cycle strobes. Read data is combinational and zero
// unless a mapped register is being read.
module pio_bus_if
    import pio_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 32'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              item_flag,
    input  logic [DATA_W-1:0] item_data,
    output logic [DATA_W-1:0] io_rdata,
    output logic              accept_en,
    output logic              take
);

    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(BASE_ADDR + OFS_STAT);
    localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(BASE_ADDR + OFS_DATA);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(BASE_ADDR + OFS_CTRL);

    reg_sel_e sel;
    logic     en_q;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = |io_wdata[DATA_W-1:2];

    // Address decode to a register select.
    always_comb begin
        if (io_addr == ADDR_STAT)      sel = SEL_STAT;
        else if (io_addr == ADDR_DATA) sel = SEL_DATA;
        else if (io_addr == ADDR_CTRL) sel = SEL_CTRL;
        else                           sel = SEL_NONE;
    end

    // Accept-enable bit, loaded by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (io_wr && sel == SEL_CTRL) begin
            en_q <= io_wdata[CTRL_EN_BIT];
        end
    end

    // Flag clear: data read or control discard.
    assign take = (io_rd && sel == SEL_DATA) ||
                  (io_wr && sel == SEL_CTRL && io_wdata[CTRL_DROP_BIT]);

    // Read multiplexer, zero when idle or unmapped.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (sel)
                SEL_STAT: io_rdata[0]           = item_flag;
                SEL_DATA: io_rdata              = item_data;
                SEL_CTRL: io_rdata[CTRL_EN_BIT] = en_q;
                default:  io_rdata              = '0;
            endcase
        end
    end

    assign accept_en = en_q;

endmodule

// File: rtl/pio_poll_port.sv
// Polled input port: one holding register, a ready flag visible to the
// processor and a four-phase valid/acknowledge toward the device.
// Raises no interrupt, so software paces transfers by polling the flag.
module pio_poll_port #(
    parameter int          DATA_W      = 8,
    parameter int          ADDR_W      = 8,
    parameter int unsigned BASE_ADDR   = 32'h40,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              dev_valid,
    output logic              dev_ack
);

    logic              valid_s;
    logic              accept_en;
    logic              take;
    logic              item_flag;
    logic [DATA_W-1:0] item_data;

    pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dev_valid),
        .sync_out (valid_s)
    );

    pio_dev_hs #(.DATA_W(DATA_W)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_s   (valid_s),
        .dev_data  (dev_data),
        .accept_en (accept_en),
        .take      (take),
        .dev_ack   (dev_ack),
        .item_flag (item_flag),
        .item_data (item_data)
    );

    pio_bus_if #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .item_flag (item_flag),
        .item_data (item_data),
        .io_rdata  (io_rdata),
        .accept_en (accept_en),
        .take      (take)
    );

endmodule

// File: rtl/pio_poll_port_chk.sv
// Assertion checker for pio_poll_port. It is bound to the top and
// observes the ports plus the wires that connect the submodules.
module pio_poll_port_chk #(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 32'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              drop_bit,
    input logic [DATA_W-1:0] io_rdata,
    input logic [DATA_W-1:0] dev_data,
    input logic              dev_valid,
    input logic              dev_ack,
    input logic              valid_s,
    input logic              accept_en,
    input logic              item_flag,
    input logic [DATA_W-1:0] item_data
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + 0);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR + 1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR + 2);

    logic mapped;
    logic clearing;
    assign mapped   = (io_addr == A_STAT) || (io_addr == A_DATA) || (io_addr == A_CTRL);
    assign clearing = (io_rd && io_addr == A_DATA) || (io_wr && io_addr == A_CTRL && drop_bit);

    AST_SYNC_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_s) |-> $past(dev_valid)) else $error("sync rose without pin"); // R2
    AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> item_flag) else $error("ack without flag"); // R3
    AST_ACK_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> item_data == $past(dev_data)) else $error("data not captured"); // R3
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack && valid_s |=> dev_ack) else $error("ack dropped early"); // R4
    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack && !valid_s |=> !dev_ack) else $error("ack not released"); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        item_flag && !clearing |=> item_flag && $stable(item_data)) else $error("overwrite while full"); // R5
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_en && !dev_ack |=> !dev_ack) else $error("accepted while disabled"); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && io_addr == A_DATA && item_flag |=> !item_flag) else $error("read did not clear"); // R6
    AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && io_addr == A_STAT |-> (io_rdata >> 1) == '0 && io_rdata[0] == item_flag) else $error("status format"); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !mapped |-> io_rdata == '0) else $error("unmapped nonzero"); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0) else $error("idle nonzero"); // R9

endmodule

bind pio_poll_port pio_poll_port_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .drop_bit  (io_wdata[1]),
    .io_rdata  (io_rdata),
    .dev_data  (dev_data),
    .dev_valid (dev_valid),
    .dev_ack   (dev_ack),
    .valid_s   (valid_s),
    .accept_en (accept_en),
    .item_flag (item_flag),
    .item_data (item_data)
);

// File: tb/pio_poll_port_bench.sv
// Self-checking bench. A behavioural reference model steps on every clock,
// and acknowledge and read data are compared after each edge.
module pio_poll_port_bench;

    localparam int DW = 8;
    localparam int AW = 8;
    localparam logic [7:0] B = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic          io_rd = 1'b0;
    logic          io_wr = 1'b0;
    logic [DW-1:0] io_wdata = '0;
    logic [DW-1:0] io_rdata;
    logic [DW-1:0] dev_data = '0;
    logic          dev_valid = 1'b0;
    logic          dev_ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state.
    bit       m_s1, m_s2, m_ack, m_flag, m_en;
    bit [7:0] m_data;

    always #4 clk = ~clk;

    pio_poll_port #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(32'h40)) u_pio_poll_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_data(dev_data),
        .dev_valid(dev_valid), .dev_ack(dev_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] exp_rdata();
        if (!io_rd) return 8'h00;
        if (io_addr == B)      return {7'b0, m_flag};
        if (io_addr == B + 1)  return m_data;
        if (io_addr == B + 2)  return {7'b0, m_en};
        return 8'h00;
    endfunction

    function automatic string rd_req();
        if (!io_rd)           return "R9 idle";
        if (io_addr == B)     return "R7 status";
        if (io_addr == B + 1) return "R6 data";
        if (io_addr == B + 2) return "R8 control";
        return "R9 unmapped";
    endfunction

    // Advance the model by one rising edge using the current inputs.
    task automatic model_edge();
        bit load, take, s2_old;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ack = 0; m_flag = 0; m_en = 0; m_data = 0;
            return;
        end
        s2_old = m_s2;
        load = !m_ack && s2_old && !m_flag && m_en;
        take = (io_rd && io_addr == B + 1) || (io_wr && io_addr == B + 2 && io_wdata[1]);
        m_s2 = m_s1;
        m_s1 = dev_valid;
        if (!m_ack) begin
            if (load) m_ack = 1;
        end else if (!s2_old) begin
            m_ack = 0;
        end
        if (load) begin
            m_flag = 1;
            m_data = dev_data;
        end else if (take) begin
            m_flag = 0;
        end
        if (io_wr && io_addr == B + 2) m_en = io_wdata[0];
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #2;
        if (rst_n) begin
            check("R4 ack", dev_ack, m_ack);
            check(rd_req(), io_rdata, exp_rdata());
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        cyc();
        d = io_rdata;
        io_rd = 1'b0; io_addr = '0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        cyc();
        io_wr = 1'b0; io_wdata = '0; io_addr = '0;
    endtask

    task automatic wait_ack(input logic v, output int n);
        n = 0;
        do begin
            cyc();
            n++;
        end while (dev_ack !== v && n < 20);
    endtask

    task automatic dev_send(input logic [7:0] d);
        int n;
        dev_data = d; dev_valid = 1'b1;
        wait_ack(1'b1, n);
        dev_valid = 1'b0;
        wait_ack(1'b0, n);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int n;

        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: reset state
        check("R1 ack", dev_ack, 1'b0);
        bus_read(B, rd);     check("R1 flag", rd, 8'h00);
        bus_read(B + 1, rd); check("R1 data", rd, 8'h00);
        bus_read(B + 2, rd); check("R1 enable", rd, 8'h00);

        // R5: disabled port ignores the device
        dev_data = 8'h3C; dev_valid = 1'b1;
        repeat (6) cyc();
        check("R5 disabled ack", dev_ack, 1'b0);
        bus_read(B, rd); check("R5 disabled flag", rd, 8'h00);
        dev_valid = 1'b0;
        repeat (3) cyc();

        bus_write(B + 2, 8'h01);
        bus_read(B + 2, rd); check("R8 enable readback", rd, 8'h01);

        // R2 and R4: latency in both directions
        dev_data = 8'hA5; dev_valid = 1'b1;
        wait_ack(1'b1, n); check("R2 rise latency", n, 3);
        bus_read(B, rd); check("R7 flag set", rd, 8'h01);
        dev_valid = 1'b0;
        wait_ack(1'b0, n); check("R4 fall latency", n, 3);
        bus_read(B + 1, rd); check("R3 captured data", rd, 8'hA5);
        bus_read(B, rd); check("R6 flag cleared", rd, 8'h00);

        // R5: second item held off while the first is unread
        dev_send(8'h11);
        dev_data = 8'h22; dev_valid = 1'b1;
        repeat (8) cyc();
        check("R5 ack withheld", dev_ack, 1'b0);
        bus_read(B + 1, rd); check("R5 first item kept", rd, 8'h11);
        wait_ack(1'b1, n); check("R5 accept after clear", n, 1);
        dev_valid = 1'b0;
        wait_ack(1'b0, n);
        bus_read(B + 1, rd); check("R6 second item", rd, 8'h22);

        // R8: discard and readback format
        dev_send(8'h5A);
        bus_read(B, rd); check("R7 flag before discard", rd, 8'h01);
        bus_write(B + 2, 8'h03);
        bus_read(B, rd); check("R8 discard clears flag", rd, 8'h00);
        bus_read(B + 2, rd); check("R8 drop bit reads zero", rd, 8'h01);
        bus_write(B + 2, 8'hFD);
        bus_read(B + 2, rd); check("R8 reserved bits zero", rd, 8'h01);

        // R9: unmapped and idle
        bus_write(B + 3, 8'h00);
        bus_write(B, 8'hFF);
        bus_read(B + 2, rd); check("R9 stray write ignored", rd, 8'h01);
        bus_read(B, rd); check("R9 status write ignored", rd, 8'h00);
        bus_read(B + 3, rd); check("R9 unmapped", rd, 8'h00);
        bus_read(8'h00, rd); check("R9 unmapped low", rd, 8'h00);
        bus_read(8'hFF, rd); check("R9 unmapped high", rd, 8'h00);
        io_addr = B + 1; cyc(); check("R9 idle data addr", io_rdata, 8'h00);
        io_addr = '0;

        // Stream of items paced by polling
        for (int i = 0; i < 16; i++) begin
            logic [7:0] item;
            item = 8'(i * 37 + 5);
            dev_send(item);
            bus_read(B, rd);
            check("R7 poll ready", rd, 8'h01);
            bus_read(B + 1, rd);
            check("R6 stream data", rd, item);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule